// File: doc/BRIEF.md
# Gated Ring Phase Differencer

This block converts the frozen state of an N-stage gated ring oscillator into one signed time-to-digital sample per conversion. When the sample strobe is high, it takes the stage vector as it stands at that clock edge and decodes it into a fine phase index between 0 and 2N-1. A wrap counter adds the number of complete ring revolutions to that index, which gives an absolute phase. The output is the absolute phase minus the absolute phase from the previous strobe. That difference is the number of stage transitions that occurred between the two samples.

The ring is only stopped between measurements and is never reset, so the block clears no state from one conversion to the next. The part of a transition that one sample did not count is counted in the next one. This carry-over is the source of first-order shaping of the quantization error. The wrap counter is narrow and rolls over freely. Its difference is taken modulo its own range, so a rollover still gives the correct forward count.

The first strobe after reset only stores a reference phase and produces no output pulse. Every later strobe produces one output word, qualified by a one-cycle valid pulse.

Top module: `gro_phase_meter`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, `valid_o` is 0 and `diff_o` is 0.
- R2: Fine decode for the registered stage vector. Let m be the number of stages, starting at stage 0 and going up in index, that equal stage 0 without a break (m is 1 to N). The fine phase is m-1 when stage 0 is 1, and N+m-1 when stage 0 is 0. Ring phase k < N therefore has stages 0..k at 1 and the rest at 0. Ring phase k >= N has stages 0..k-N at 0 and the rest at 1.
- R3: The wrap counter advances by exactly one on every clock edge where `wrap_i` is 1 and was 0 at the previous edge, and is otherwise unchanged.
- R4: On a strobe edge, with a reference already held, `diff_o` becomes (coarse difference) * 2N + (fine difference). The coarse difference is taken unsigned modulo 2^CNT_W. `valid_o` is 1 for exactly the one cycle after the strobe edge.
- R5: The first strobe after reset only stores the reference phase. `valid_o` stays 0 for it, and the next strobe gives a valid difference against that reference.
- R6: Rollover of the wrap counter between two strobes does not disturb the result, provided fewer than 2^CNT_W * 2N transitions occur between the strobes.
- R7: Between strobes, `diff_o` holds its last value and `valid_o` is 0. The stored reference is kept, not cleared.
- R8: A wrap edge that occurs on the same clock edge as the strobe is counted in that sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| stage_i | input | N_STAGES | Ring stage outputs, held frozen by the gating |
| wrap_i | input | 1 | Tap from the chosen stage whose rising edges count revolutions |
| strobe_i | input | 1 | Sample strobe: take the phase on this edge |
| diff_o | output | CNT_W+clog2(2*N_STAGES)+1 | Signed transition count since the previous sample |
| valid_o | output | 1 | One-cycle pulse qualifying diff_o |

## Verification
Two functions can fall on the same clock edge: a wrap-counter increment and the sample strobe. The bench provokes this by sizing a measurement so that the last ring advance crosses from phase 2N-1 to phase 0 in the strobe cycle itself. A correct result then equals the number of steps driven, which can only happen if the coarse count already includes that edge. Long runs that roll the counter over are judged in the same way, against the number of steps driven.

// File: rtl/gro_pkg.sv
package gro_pkg;
  // width of a fine phase index for an n-stage ring (2n states)
  function automatic int unsigned fine_bits(input int unsigned n);
    return $clog2(2 * n);
  endfunction
endpackage

// File: rtl/gro_fine_decode.sv
module gro_fine_decode #(
  parameter int unsigned N      = 7,
  parameter int unsigned FINE_W = gro_pkg::fine_bits(N)
) (
  input  logic [N-1:0]      stage_i,
  output logic [FINE_W-1:0] fine_o
);
  localparam int unsigned TWO_N = 2 * N;

  logic [FINE_W-1:0] run_len;
  logic              run_on;

  always_comb begin
    run_len = FINE_W'(1);
    run_on  = 1'b1;
    for (int j = 1; j < int'(N); j++) begin
      if (run_on && (stage_i[j] == stage_i[0])) run_len = run_len + 1'b1;
      else run_on = 1'b0;
    end
    fine_o = (run_len - 1'b1) + (stage_i[0] ? FINE_W'(0) : FINE_W'(N));
  end

  // R2: decoded index stays inside the 2N-state cycle
  always_comb begin
    assert_fine_range_R2: assert (32'(fine_o) < TWO_N)
      else $error("fine phase out of range");
  end
endmodule

// File: rtl/gro_wrap_counter.sv
module gro_wrap_counter #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap_i,
  output logic [CNT_W-1:0] coarse_nxt_o
);
  logic             tap_q, tap_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rise;

  always_comb begin
    rise  = wrap_i & ~tap_q;
    tap_d = wrap_i;
    cnt_d = cnt_q + CNT_W'(rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      tap_q <= tap_d;
      cnt_q <= cnt_d;
    end
  end

  assign coarse_nxt_o = cnt_d;

  // R3: the count moves by at most one step per edge
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R3: a rise seen on the tap always advances the count
  assert_rise_counted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && !tap_q) |=> (cnt_q != $past(cnt_q)));
endmodule

// File: rtl/gro_phase_diff.sv
module gro_phase_diff #(
  parameter int unsigned N      = 7,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned FINE_W = gro_pkg::fine_bits(N),
  parameter int unsigned OUT_W  = CNT_W + FINE_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    strobe_i,
  input  logic [CNT_W-1:0]        coarse_i,
  input  logic [FINE_W-1:0]       fine_i,
  output logic signed [OUT_W-1:0] diff_o,
  output logic                    valid_o
);
  localparam logic [OUT_W-1:0] SPAN = OUT_W'(2 * N);
  localparam int unsigned      PADF = OUT_W - FINE_W;
  localparam int unsigned      PADC = OUT_W - CNT_W;

  logic [CNT_W-1:0]        ref_c_q, ref_c_d;
  logic [FINE_W-1:0]       ref_f_q, ref_f_d;
  logic                    primed_q, primed_d;
  logic                    valid_q, valid_d;
  logic signed [OUT_W-1:0] diff_q, diff_d;

  logic [CNT_W-1:0]        dcoarse;
  logic signed [OUT_W-1:0] dfine;
  logic [OUT_W-1:0]        coarse_part;

  always_comb begin
    dcoarse     = coarse_i - ref_c_q;  // modulo 2^CNT_W corrects rollover
    coarse_part = {{PADC{1'b0}}, dcoarse} * SPAN;
    dfine       = $signed({{PADF{1'b0}}, fine_i}) - $signed({{PADF{1'b0}}, ref_f_q});

    ref_c_d  = ref_c_q;
    ref_f_d  = ref_f_q;
    primed_d = primed_q;
    diff_d   = diff_q;
    valid_d  = 1'b0;
    if (strobe_i) begin
      ref_c_d  = coarse_i;
      ref_f_d  = fine_i;
      primed_d = 1'b1;
      if (primed_q) begin
        diff_d  = $signed(coarse_part) + dfine;
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_c_q  <= '0;
      ref_f_q  <= '0;
      primed_q <= 1'b0;
      valid_q  <= 1'b0;
      diff_q   <= '0;
    end else begin
      ref_c_q  <= ref_c_d;
      ref_f_q  <= ref_f_d;
      primed_q <= primed_d;
      valid_q  <= valid_d;
      diff_q   <= diff_d;
    end
  end

  assign diff_o  = diff_q;
  assign valid_o = valid_q;

  // R4: every valid pulse answers a strobe one edge earlier
  assert_valid_follows_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(strobe_i));

  // R5: the first strobe after reset yields no output
  assert_first_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !primed_q) |=> !valid_q);

  // R7: without a strobe the output word and the reference are kept
  assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> ($stable(diff_q) && $stable(ref_f_q) && $stable(ref_c_q) && !valid_q));
endmodule

// File: rtl/gro_phase_meter.sv
module gro_phase_meter #(
  parameter int unsigned N_STAGES = 7,
  parameter int unsigned CNT_W    = 6,
  localparam int unsigned FINE_W  = gro_pkg::fine_bits(N_STAGES),
  localparam int unsigned OUT_W   = CNT_W + FINE_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_STAGES-1:0]     stage_i,
  input  logic                    wrap_i,
  input  logic                    strobe_i,
  output logic signed [OUT_W-1:0] diff_o,
  output logic                    valid_o
);
  logic             rst_meta_q, rst_sync_q;
  logic [CNT_W-1:0] coarse_nxt;
  logic [FINE_W-1:0] fine;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  gro_fine_decode #(.N(N_STAGES), .FINE_W(FINE_W)) u_decode (
    .stage_i (stage_i),
    .fine_o  (fine)
  );

  gro_wrap_counter #(.CNT_W(CNT_W)) u_wrap (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .wrap_i       (wrap_i),
    .coarse_nxt_o (coarse_nxt)
  );

  gro_phase_diff #(.N(N_STAGES), .CNT_W(CNT_W), .FINE_W(FINE_W), .OUT_W(OUT_W)) u_diff (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .strobe_i (strobe_i),
    .coarse_i (coarse_nxt),
    .fine_i   (fine),
    .diff_o   (diff_o),
    .valid_o  (valid_o)
  );

  // R1: outputs are quiet while the synchronized reset is held
  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_sync_q |=> (!valid_o && (diff_o == '0)));
endmodule

// File: tb/gro_phase_meter_tb.sv
module gro_phase_meter_tb;
  localparam int N     = 7;
  localparam int CNT_W = 6;
  localparam int OUT_W = CNT_W + $clog2(2 * N) + 1;
  localparam int MAXSTEP = 5;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic [N-1:0]            stage;
  logic                    wrap;
  logic                    strobe;
  logic signed [OUT_W-1:0] diff;
  logic                    valid;

  int checks = 0;
  int errors = 0;
  int ph     = 0;
  bit done   = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  gro_phase_meter #(.N_STAGES(N), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .stage_i(stage), .wrap_i(wrap),
    .strobe_i(strobe), .diff_o(diff), .valid_o(valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural ring: pattern for phase p as stated in R2
  task automatic advance(input int k);
    int p;
    ph += k;
    p = ph % (2 * N);
    for (int j = 0; j < N; j++)
      stage[j] = (p < N) ? (j <= p) : !(j <= p - N);
    wrap = stage[0];
  endtask

  // drive one measurement of 'steps' transitions; last advance shares the strobe cycle
  task automatic sample(input int steps, input string tag, input bit expect_out);
    int rem = steps;
    logic signed [OUT_W-1:0] held;
    while (rem > MAXSTEP) begin
      @(negedge clk); advance(MAXSTEP); strobe = 1'b0; rem -= MAXSTEP;
    end
    @(negedge clk); advance(rem); strobe = 1'b1;
    if (expect_out) begin exp_q.push_back(steps); tag_q.push_back(tag); end
    @(negedge clk); strobe = 1'b0;
    if (!expect_out) chk(valid == 1'b0, "R5 first strobe", int'(valid), 0);
    held = diff;
    @(negedge clk);
    chk(valid == 1'b0 && diff == held, "R7 hold", int'(diff), int'(held));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; strobe = 1'b0;
    repeat (3) @(negedge clk);
    chk(valid == 1'b0 && diff == '0, "R1 reset state", int'(diff), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid == 1'b0 && diff == '0, "R1 after release", int'(diff), 0);
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected valid", int'(diff), 0);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(diff) == e, t, int'(diff), e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; strobe = 1'b0; stage = '0; wrap = 1'b0;
    advance(3);
    do_reset();                                   // R1
    sample(2, "R5", 1'b0);                        // R5 reference only
    for (int s = 1; s < 2 * N; s++) sample(s, "R2 fine step", 1'b1);  // R2
    sample(0, "R4 zero", 1'b1);                   // R4
    sample(14, "R3 one wrap", 1'b1);              // R3
    sample(27, "R3 two wraps", 1'b1);             // R3
    sample(40, "R4 multi", 1'b1);                 // R4
    // R8: land exactly on phase 0 in the strobe cycle
    sample(2 * N - (ph % (2 * N)) + 2 * N, "R8 wrap on strobe", 1'b1);
    sample(5, "R8 after", 1'b1);
    // R6: counter rollover across long measurements
    for (int r = 0; r < 3; r++) sample(800, "R6 rollover", 1'b1);
    sample(7, "R6 after", 1'b1);
    // R5 again after a mid-run reset; ring phase kept
    do_reset();
    sample(9, "R5", 1'b0);
    sample(11, "R5 new reference", 1'b1);
    sample(2 * N - (ph % (2 * N)), "R8 land on zero", 1'b1);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule